// File: doc/BRIEF.md
# Waveform Memory Programming Controller

This block sequences access to the sample memories of a waveform generator. Software-side logic loads a 26-bit control word. The word sets a start address, a burst length, a transfer direction and a choice of RAM copy, and it carries a start flag. While the flag is set, the block walks an address range. Each strobe on the data side moves one 64-bit word between that side and one of the paired even/odd RAMs. A write can go to copy A, to copy B, or to both copies at once. A read returns the word from the chosen copy on a data-out port with a valid strobe. The flag clears itself when the last word has moved, and a one-cycle done pulse marks the end of the access.

Each RAM location holds four 16-bit samples, so one address spans eight waveform points across the even and odd memories. The burst field therefore holds (points / 8) − 1, and zero means a single address. A start address of zero with the largest burst covers the full 2048-address depth. Nonzero start addresses let several shorter waveforms share the memory. Address arithmetic wraps at the memory depth.

While no access is running, a separate playback address steps through the programmed range once per cycle, from the start address to start + burst, and then returns to the start. The serial data path itself sits outside the block. That path runs at less than one sixteenth of the core clock, so strobes arrive with idle cycles between them.

Top module: `wfm_prog_ctrl`

## Requirements
- R1: After reset, ctrl_q is 0 (read direction, copy A, not busy), play_addr is 0, and done, rd_valid, ram_we and all four RAM enables are 0.
- R2: A cfg_wr accepted at a clock edge copies cfg_word into ctrl_q for the next cycle, with the field layout start address [10:0], burst [21:11], direction [22] (1 = write), copy select [23] (1 = copy B), broadcast [24] and busy/start [25].
- R3: While ctrl_q[25] is 1, cfg_wr is ignored and ctrl_q keeps its value.
- R4: While busy, each cycle with xfer_stb high moves one word at ram_addr. The first strobe at an address targets the even RAM and the second targets the odd RAM, and the address then advances by one. The addresses run from start to start + burst, modulo 2048, so a burst of 0 covers one address and two words.
- R5: On a write (direction 1), ram_we is 1 while busy and ram_wdata equals xfer_wdata. With broadcast 0, copy select 0 enables copy A and copy select 1 enables copy B. With broadcast 1, both copies are enabled in the same cycle.
- R6: On a read (direction 0), only the copy chosen by copy select is enabled and broadcast has no effect. One cycle after the strobe, rd_valid is 1 and rd_data holds the word that RAM returned.
- R7: done is high for exactly one cycle, in the cycle after the odd-word strobe at address start + burst. ctrl_q[25] reads 0 in that same cycle.
- R8: While not busy, play_addr advances by one each cycle from the start address. After start + burst (modulo 2048) it returns to the start address. It is reloaded with the start address when a control word is accepted and again at done, and it holds its value while busy.
- R9: The four RAM enables are all 0 whenever the block is not busy or xfer_stb is low, even if xfer_stb is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the control word |
| cfg_word | input | 26 | Control word to load |
| ctrl_q | output | 26 | Current control word, with the self-clearing busy bit at [25] |
| xfer_stb | input | 1 | One word transfer per high cycle |
| xfer_wdata | input | 64 | Word to write |
| ram_addr | output | 11 | Access address to all four RAMs |
| ram_wdata | output | 64 | Write data to all four RAMs |
| ram_we | output | 1 | Write enable, 1 for a write access |
| ram_a_even_en | output | 1 | Enable, copy A even RAM |
| ram_a_odd_en | output | 1 | Enable, copy A odd RAM |
| ram_b_even_en | output | 1 | Enable, copy B even RAM |
| ram_b_odd_en | output | 1 | Enable, copy B odd RAM |
| ram_a_even_rdata | input | 64 | Read data, copy A even RAM (one-cycle latency) |
| ram_a_odd_rdata | input | 64 | Read data, copy A odd RAM |
| ram_b_even_rdata | input | 64 | Read data, copy B even RAM |
| ram_b_odd_rdata | input | 64 | Read data, copy B odd RAM |
| rd_valid | output | 1 | Read word available on rd_data |
| rd_data | output | 64 | Word returned by a read |
| done | output | 1 | One-cycle pulse at the end of an access |
| play_addr | output | 11 | Playback address while idle |

## Verification
The RAM enables, ram_addr and ram_we follow xfer_stb in the same cycle, so the bench raises the strobe at a falling edge and checks them 1 ns later. ctrl_q and the reloaded play_addr change at the next rising edge, so the bench reads them at the falling edge that follows. rd_valid, rd_data and done come one rising edge after the strobe and are checked at the next falling edge, and done is checked to be low again one cycle later. Playback is followed cycle by cycle against an arithmetic model of start + (n mod (burst + 1)), including ranges that wrap past address 2047. Every copy-select and broadcast combination is first written and then read back from both copies against a bench-side shadow of what each RAM should hold.

// File: rtl/wfm_prog_pkg.sv
// Package: shared widths and the control word layout for the waveform
// memory programming controller. Assumes a 2048-deep, 64-bit-wide RAM set.
package wfm_prog_pkg;
    localparam int ADDR_W = 11;
    localparam int WORD_W = 64;
    localparam int CTRL_W = 2 * ADDR_W + 4;

    // Control word, most significant field first.
    typedef struct packed {
        logic              go;     // [25] start / busy, self-clearing
        logic              both;   // [24] broadcast write to both copies
        logic              selb;   // [23] choose copy B
        logic              wr;     // [22] 1 = write, 0 = read
        logic [ADDR_W-1:0] burst;  // [21:11] addresses - 1
        logic [ADDR_W-1:0] base;   // [10:0] start address
    } ctrl_t;
endpackage

// File: rtl/wfm_ctrl_reg.sv
// Control register: holds the control word and accepts a new one only while
// no access runs. The start bit clears when the sequencer signals the last step.
// Assumes clr_go is asserted only while go is set.
module wfm_ctrl_reg
    import wfm_prog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_wr,
    input  ctrl_t cfg_in,
    input  logic  clr_go,
    output ctrl_t ctrl,
    output logic  accept
);
    // A new word is taken only when idle.
    assign accept = cfg_wr && !ctrl.go;

    // Load the word, or drop the start bit at the end of an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (accept) begin
            ctrl <= cfg_in;
        end else if (clr_go) begin
            ctrl.go <= 1'b0;
        end
    end
endmodule

// File: rtl/wfm_seq.sv
// Access sequencer: walks base..base+burst (modulo the depth), two strobes per
// address (even, then odd), and flags the final strobe. Assumes strobes arrive
// only as single words, one per high cycle of stb.
module wfm_seq
    import wfm_prog_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    input  logic [AW-1:0] base_new,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] burst,
    input  logic          stb,
    output logic [AW-1:0] addr,
    output logic          half,
    output logic          last_step,
    output logic          done
);
    logic [AW-1:0] end_addr;
    logic          step;

    // Final address of the range, wrapping naturally at the depth.
    assign end_addr  = base + burst;
    assign step      = go && stb;
    assign last_step = step && half && (addr == end_addr);

    // Track address and half, and pulse done after the final odd word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            half <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= last_step;
            if (load_go) begin
                addr <= base_new;
                half <= 1'b0;
            end else if (step) begin
                half <= !half;
                if (half && (addr != end_addr)) begin
                    addr <= addr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wfm_play.sv
// Playback address generator: while idle, steps once per cycle through
// base..base+burst and wraps to base. Reloads on demand, holds while busy.
module wfm_play
    import wfm_prog_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [AW-1:0] reload_base,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] burst,
    output logic [AW-1:0] play_addr
);
    logic [AW-1:0] end_addr;

    assign end_addr = base + burst;

    // Reload, hold while an access runs, otherwise cycle through the range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_addr <= '0;
        end else if (reload) begin
            play_addr <= reload_base;
        end else if (!go) begin
            play_addr <= (play_addr == end_addr) ? base : play_addr + 1'b1;
        end
    end
endmodule

// File: rtl/wfm_ram_port.sv
// RAM port logic: decodes the four enables from copy selection and half,
// and registers the read-return routing for the one-cycle RAM latency.
// Assumes every RAM returns data the cycle after its enable.
module wfm_ram_port
    import wfm_prog_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NCOPY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             wr,
    input  logic             both,
    input  logic             selb,
    input  logic             stb,
    input  logic             half,
    input  logic [DW-1:0]    rdata_even [NCOPY],
    input  logic [DW-1:0]    rdata_odd  [NCOPY],
    output logic [NCOPY-1:0] en_even,
    output logic [NCOPY-1:0] en_odd,
    output logic             we,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    logic             step;
    logic [NCOPY-1:0] tgt;
    logic             rd_odd_q;
    logic             rd_b_q;

    assign step = go && stb;
    assign we   = go && wr;

    // Copy targets: writes may broadcast, reads follow the copy select only.
    assign tgt[0] = wr ? (both || !selb) : !selb;
    assign tgt[1] = wr ? (both || selb) : selb;

    for (genvar g = 0; g < NCOPY; g++) begin : g_copy
        assign en_even[g] = step && tgt[g] && !half;
        assign en_odd[g]  = step && tgt[g] && half;
    end

    // Remember which RAM answers a read in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_odd_q <= 1'b0;
            rd_b_q   <= 1'b0;
        end else begin
            rd_valid <= step && !wr;
            rd_odd_q <= half;
            rd_b_q   <= selb;
        end
    end

    // Route the answering RAM to the data-out port.
    always_comb begin
        case ({rd_b_q, rd_odd_q})
            2'b00:   rd_data = rdata_even[0];
            2'b01:   rd_data = rdata_odd[0];
            2'b10:   rd_data = rdata_even[1];
            default: rd_data = rdata_odd[1];
        endcase
    end
endmodule

// File: rtl/wfm_prog_ctrl.sv
// Top: waveform memory programming controller. Connects the control
// register, the access sequencer, the playback address generator and the RAM
// port logic. Assumes the external RAMs have a one-cycle read latency.
module wfm_prog_ctrl
    import wfm_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_word,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              xfer_stb,
    input  logic [WORD_W-1:0] xfer_wdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_a_even_en,
    output logic              ram_a_odd_en,
    output logic              ram_b_even_en,
    output logic              ram_b_odd_en,
    input  logic [WORD_W-1:0] ram_a_even_rdata,
    input  logic [WORD_W-1:0] ram_a_odd_rdata,
    input  logic [WORD_W-1:0] ram_b_even_rdata,
    input  logic [WORD_W-1:0] ram_b_odd_rdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] play_addr
);
    ctrl_t             cfg_in;
    ctrl_t             ctrl;
    logic              accept;
    logic              last_step;
    logic              half;
    logic [1:0]        en_even;
    logic [1:0]        en_odd;
    logic [WORD_W-1:0] rdata_even [2];
    logic [WORD_W-1:0] rdata_odd  [2];

    assign cfg_in = ctrl_t'(cfg_word);
    assign ctrl_q = ctrl;

    assign rdata_even[0] = ram_a_even_rdata;
    assign rdata_even[1] = ram_b_even_rdata;
    assign rdata_odd[0]  = ram_a_odd_rdata;
    assign rdata_odd[1]  = ram_b_odd_rdata;

    assign ram_wdata     = xfer_wdata;
    assign ram_a_even_en = en_even[0];
    assign ram_b_even_en = en_even[1];
    assign ram_a_odd_en  = en_odd[0];
    assign ram_b_odd_en  = en_odd[1];

    wfm_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .cfg_in (cfg_in),
        .clr_go (last_step),
        .ctrl   (ctrl),
        .accept (accept)
    );

    wfm_seq #(.AW(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (accept && cfg_in.go),
        .base_new  (cfg_in.base),
        .go        (ctrl.go),
        .base      (ctrl.base),
        .burst     (ctrl.burst),
        .stb       (xfer_stb),
        .addr      (ram_addr),
        .half      (half),
        .last_step (last_step),
        .done      (done)
    );

    wfm_play #(.AW(ADDR_W)) u_play (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (accept || last_step),
        .reload_base (accept ? cfg_in.base : ctrl.base),
        .go          (ctrl.go),
        .base        (ctrl.base),
        .burst       (ctrl.burst),
        .play_addr   (play_addr)
    );

    wfm_ram_port #(.DW(WORD_W), .NCOPY(2)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (ctrl.go),
        .wr         (ctrl.wr),
        .both       (ctrl.both),
        .selb       (ctrl.selb),
        .stb        (xfer_stb),
        .half       (half),
        .rdata_even (rdata_even),
        .rdata_odd  (rdata_odd),
        .en_even    (en_even),
        .en_odd     (en_odd),
        .we         (ram_we),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/wfm_prog_chk.sv
// Checker: port-level properties of the programming controller, bound to
// every instance of the top module.
module wfm_prog_chk
    import wfm_prog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              ram_we,
    input logic              ram_a_even_en,
    input logic              ram_a_odd_en,
    input logic              ram_b_even_en,
    input logic              ram_b_odd_en,
    input logic              rd_valid,
    input logic              done,
    input logic [ADDR_W-1:0] play_addr
);
    logic busy;
    logic any_even;
    logic any_odd;

    assign busy     = ctrl_q[CTRL_W-1];
    assign any_even = ram_a_even_en || ram_b_even_en;
    assign any_odd  = ram_a_odd_en || ram_b_odd_en;

    AST_EVEN_ODD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_even && any_odd)); // R4
    AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(any_even || any_odd)); // R9
    AST_DUAL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_a_even_en && ram_b_even_en) || (ram_a_odd_en && ram_b_odd_en)) |-> ram_we); // R5
    AST_RD_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past((any_even || any_odd) && !ram_we)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_BUSY_IGNORES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> $stable(ctrl_q[CTRL_W-5:0])); // R3
    AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(play_addr)); // R8
endmodule

bind wfm_prog_ctrl wfm_prog_chk u_chk (.*);

// File: tb/tb_wfm_prog_ctrl.sv
`timescale 1ns/1ps
module tb_wfm_prog_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [25:0] cfg_word = '0;
    logic [25:0] ctrl_q;
    logic        xfer_stb = 1'b0;
    logic [63:0] xfer_wdata = '0;
    logic [10:0] ram_addr;
    logic [63:0] ram_wdata;
    logic        ram_we;
    logic        a_e, a_o, b_e, b_o;
    logic [63:0] r_ae = '0, r_ao = '0, r_be = '0, r_bo = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        done;
    logic [10:0] play_addr;

    int nchk = 0;
    int nerr = 0;
    int pass_id = 0;

    // RAM models (16 deep, indexed by the low address bits) and bench shadows.
    logic [63:0] m_ae [16], m_ao [16], m_be [16], m_bo [16];
    logic [63:0] s_ae [16], s_ao [16], s_be [16], s_bo [16];

    always #2 clk = ~clk;

    wfm_prog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .ctrl_q(ctrl_q), .xfer_stb(xfer_stb), .xfer_wdata(xfer_wdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_a_even_en(a_e), .ram_a_odd_en(a_o),
        .ram_b_even_en(b_e), .ram_b_odd_en(b_o),
        .ram_a_even_rdata(r_ae), .ram_a_odd_rdata(r_ao),
        .ram_b_even_rdata(r_be), .ram_b_odd_rdata(r_bo),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .play_addr(play_addr)
    );

    always @(posedge clk) begin
        if (a_e) begin if (ram_we) m_ae[ram_addr[3:0]] <= ram_wdata; else r_ae <= m_ae[ram_addr[3:0]]; end
        if (a_o) begin if (ram_we) m_ao[ram_addr[3:0]] <= ram_wdata; else r_ao <= m_ao[ram_addr[3:0]]; end
        if (b_e) begin if (ram_we) m_be[ram_addr[3:0]] <= ram_wdata; else r_be <= m_be[ram_addr[3:0]]; end
        if (b_o) begin if (ram_we) m_bo[ram_addr[3:0]] <= ram_wdata; else r_bo <= m_bo[ram_addr[3:0]]; end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cfg(input logic [25:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // One strobe; enables checked in the strobe cycle, results one cycle later.
    task automatic step(input logic [63:0] d, input logic [10:0] ea, input logic h,
                        input logic ta, input logic tb, input logic wr,
                        input logic last, input logic [63:0] rexp, input logic [10:0] base);
        @(negedge clk); xfer_stb = 1'b1; xfer_wdata = d; #1;
        chk("R4 address", 64'(ram_addr), 64'(ea));
        chk(wr ? "R5 enables" : "R6 enables", 64'({a_e, a_o, b_e, b_o}),
            64'({ta & !h, ta & h, tb & !h, tb & h}));
        chk("R5 write enable", 64'(ram_we), 64'(wr));
        if (wr) chk("R5 write data", ram_wdata, d);
        @(negedge clk); xfer_stb = 1'b0;
        chk("R6 read valid", 64'(rd_valid), 64'(!wr));
        if (!wr) chk("R6 read data", rd_data, rexp);
        chk("R7 done", 64'(done), 64'(last));
        if (last) chk("R7 busy cleared", 64'(ctrl_q[25]), 64'd0);
        chk("R8 playback hold", 64'(play_addr), 64'(base));
    endtask

    task automatic burst(input logic [10:0] b, input logic [10:0] n, input logic wr,
                         input logic s1, input logic s2, input logic poke);
        logic [25:0] w;
        logic        ta, tb;
        w = {1'b1, s2, s1, wr, n, b};
        pass_id++;
        cfg(w);
        chk("R2 field layout", 64'(ctrl_q), 64'(w));
        chk("R8 reload on accept", 64'(play_addr), 64'(b));
        #1 chk("R9 no strobe no enable", 64'({a_e, a_o, b_e, b_o}), 64'd0);
        if (poke) begin
            cfg(~w & 26'h1FF_FFFF);
            chk("R3 busy ignores config", 64'(ctrl_q), 64'(w));
        end
        ta = wr ? (s2 | !s1) : !s1;
        tb = wr ? (s2 | s1) : s1;
        for (int k = 0; k <= int'(n); k++) begin
            for (int h = 0; h < 2; h++) begin
                logic [10:0] a;
                logic [3:0]  ix;
                logic [63:0] d, rexp;
                a  = b + 11'(k);
                ix = a[3:0];
                d  = {16'(pass_id), 16'(a), 16'(h), 16'(k)};
                if (s1) rexp = h ? s_bo[ix] : s_be[ix];
                else    rexp = h ? s_ao[ix] : s_ae[ix];
                step(d, a, h[0], ta, tb, wr, (k == int'(n)) && (h == 1), rexp, b);
                if (wr) begin
                    if (ta) begin if (h == 1) s_ao[ix] = d; else s_ae[ix] = d; end
                    if (tb) begin if (h == 1) s_bo[ix] = d; else s_be[ix] = d; end
                end
            end
        end
        @(negedge clk);
        chk("R7 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic play(input logic [10:0] b, input logic [10:0] n, input int cycles);
        cfg({1'b0, 3'b000, 1'b0, n, b});
        chk("R8 reload on accept", 64'(play_addr), 64'(b));
        for (int j = 1; j <= cycles; j++) begin
            @(negedge clk);
            chk("R8 playback cycle", 64'(play_addr), 64'(11'(b + 11'(j % (int'(n) + 1)))));
        end
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_ae[i] = '0; m_ao[i] = '0; m_be[i] = '0; m_bo[i] = '0;
            s_ae[i] = '0; s_ao[i] = '0; s_be[i] = '0; s_bo[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", 64'(ctrl_q), 64'd0);
        chk("R1 play", 64'(play_addr), 64'd0);
        chk("R1 done/valid/we", 64'({done, rd_valid, ram_we}), 64'd0);
        chk("R1 enables", 64'({a_e, a_o, b_e, b_o}), 64'd0);
        // R9 strobe while idle does nothing
        xfer_stb = 1'b1; #1;
        chk("R9 idle strobe enables", 64'({a_e, a_o, b_e, b_o, ram_we}), 64'd0);
        @(negedge clk); xfer_stb = 1'b0;
        chk("R9 idle strobe no read", 64'(rd_valid), 64'd0);
        chk("R1 play stays", 64'(play_addr), 64'd0);
        // R5 writes for each target combination, wrapping past 2047 (R4)
        burst(11'd2046, 11'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        burst(11'd0,    11'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        burst(11'd4,    11'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        burst(11'd6,    11'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        // R6 read back both copies; broadcast bit set on the first read
        burst(11'd2046, 11'd8, 1'b0, 1'b0, 1'b1, 1'b0);
        burst(11'd2046, 11'd8, 1'b0, 1'b1, 1'b0, 1'b1);
        // R8 playback ranges
        play(11'd2045, 11'd4, 12);
        play(11'd5,    11'd0, 4);
        play(11'd100,  11'd2, 9);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule